// File: doc/BRIEF.md
# Local-History Branch Direction Predictor

This block predicts the direction of conditional branches from each branch's own recent behaviour. It keeps a small bank of history registers, one per tracked branch. Each register shifts in outcomes with the newest one at bit 0. The value of the register selects an entry in a shared table of single-bit counters, and that counter gives the guess.

A front-end stage presents a branch index on the predict port. In the same cycle it gets back the direction and the history value that was used, called the checkpoint. On the next clock edge the predicted direction is shifted speculatively into that branch's history, so that back-to-back predictions of the same branch see the guessed path. When the branch resolves later, the back end returns the branch index, the checkpoint, the direction that was predicted and the real outcome. The counter selected by the checkpoint is then overwritten with the outcome. If the guess was wrong, the branch's history is rebuilt from the checkpoint with the real outcome shifted in.

Top module: `lhp_local_predictor`

## Requirements
- R1: While reset is low at a clock edge, every history register and every counter is cleared to 0 by that edge.
- R2: In the cycle a branch index is presented, the predicted direction is the counter selected by that branch's current history: 0 means not taken, 1 means taken.
- R3: In the same cycle, the checkpoint output equals that branch's history before any update of this cycle.
- R4: A valid prediction that is not overridden shifts the predicted direction into bit 0 of the branch's history at the next edge. Every older bit moves up one place and the top bit is dropped.
- R5: A cycle with no valid prediction and no wrong resolution leaves every history unchanged.
- R6: Every valid resolution writes the real outcome into the counter indexed by the returned checkpoint, whether or not the guess was right.
- R7: A valid resolution whose predicted and real directions differ sets that branch's history to the checkpoint shifted up one place, with the real outcome in bit 0.
- R8: A valid resolution whose guess was right leaves that branch's history unaltered.
- R9: When a repair and a prediction hit the same branch in one cycle, the repair value is stored and the speculative shift is discarded.
- R10: Resolution fields presented while the resolve-valid input is low change neither the counters nor the histories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_valid | input | 1 | A prediction is requested this cycle |
| pred_br | input | BR_W | Index of the branch to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_ckpt | output | HIST_W | History value used for this prediction |
| res_valid | input | 1 | A resolution is presented this cycle |
| res_br | input | BR_W | Index of the resolving branch |
| res_ckpt | input | HIST_W | Checkpoint returned at prediction time |
| res_taken | input | 1 | Real outcome, 1 = taken |
| res_pred_taken | input | 1 | Direction that had been predicted |

## Verification
The direction and checkpoint are combinational and are due in the same cycle the index is applied. The bench drives inputs just after the falling edge and samples these outputs a few nanoseconds later, before the rising edge. A history shift, a counter write or a repair takes effect at the next rising edge. So the effect of any update is checked through the predict outputs of a later cycle, at the earliest in the vector that follows. Reset clearing is checked the same way, in the first prediction after reset is released.

// File: rtl/lhp_pkg.sv
// Package: shared defaults and types for the local-history predictor.
// Assumes: users derive index widths from these defaults or their own overrides.
package lhp_pkg;

    localparam int DEF_NUM_BR = 4;
    localparam int DEF_HIST_W = 3;

    // Direction encoding used at every port of the block.
    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;

endpackage

// File: rtl/lhp_history_bank.sv
// Module: bank of per-branch local history registers.
// Each register takes a repair value or a speculative one-bit shift,
// and a repair has priority over a shift aimed at the same entry.
// Assumes: HIST_W >= 2, NUM_BR >= 2, synchronous active-low reset.
module lhp_history_bank #(
    parameter int NUM_BR = lhp_pkg::DEF_NUM_BR,
    parameter int HIST_W = lhp_pkg::DEF_HIST_W,
    localparam int BR_W  = $clog2(NUM_BR)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     spec_we,
    input  logic [BR_W-1:0]          spec_idx,
    input  logic                     spec_bit,
    input  logic                     fix_we,
    input  logic [BR_W-1:0]          fix_idx,
    input  logic [HIST_W-1:0]        fix_val,
    output logic [NUM_BR*HIST_W-1:0] hist_flat
);

    for (genvar g = 0; g < NUM_BR; g++) begin : g_entry
        logic [HIST_W-1:0] hist_q;
        logic              fix_hit;
        logic              spec_hit;

        // Decode whether this entry is the target of each update.
        always_comb begin
            fix_hit  = fix_we  && (fix_idx  == BR_W'(g));
            spec_hit = spec_we && (spec_idx == BR_W'(g));
        end

        // Hold the history: clear, repair, or shift in a guess.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist_q <= '0;
            end else if (fix_hit) begin
                hist_q <= fix_val;
            end else if (spec_hit) begin
                hist_q <= {hist_q[HIST_W-2:0], spec_bit};
            end
        end

        assign hist_flat[g*HIST_W +: HIST_W] = hist_q;
    end

endmodule

// File: rtl/lhp_counter_table.sv
// Module: table of single-bit direction counters indexed by history value.
// One asynchronous read port, one write port, writes land at the clock edge.
// Assumes: synchronous active-low reset clears every counter.
module lhp_counter_table #(
    parameter int HIST_W  = lhp_pkg::DEF_HIST_W,
    localparam int DEPTH  = 1 << HIST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_idx,
    output logic              rd_bit,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  logic              wr_bit,
    output logic [DEPTH-1:0]  ctr_flat
);

    for (genvar e = 0; e < DEPTH; e++) begin : g_ctr
        logic ctr_q;

        // Store one counter bit; clear on reset, overwrite on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctr_q <= 1'b0;
            end else if (wr_en && (wr_idx == HIST_W'(e))) begin
                ctr_q <= wr_bit;
            end
        end

        assign ctr_flat[e] = ctr_q;
    end

    // Select the counter addressed by the read index.
    always_comb begin
        rd_bit = ctr_flat[rd_idx];
    end

endmodule

// File: rtl/lhp_local_predictor.sv
// Module: top of the local-history direction predictor.
// Predict: returns the counter at the branch's history and that history
// as a checkpoint, then shifts the guess in speculatively.
// Resolve: writes the outcome to the counter at the checkpoint and, if the
// guess was wrong, rebuilds the history from the checkpoint.
// Assumes: NUM_BR >= 2, HIST_W >= 2, synchronous active-low reset.
module lhp_local_predictor
    import lhp_pkg::*;
#(
    parameter int NUM_BR = DEF_NUM_BR,
    parameter int HIST_W = DEF_HIST_W,
    localparam int BR_W  = $clog2(NUM_BR),
    localparam int DEPTH = 1 << HIST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid,
    input  logic [BR_W-1:0]   pred_br,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_ckpt,
    input  logic              res_valid,
    input  logic [BR_W-1:0]   res_br,
    input  logic [HIST_W-1:0] res_ckpt,
    input  logic              res_taken,
    input  logic              res_pred_taken
);

    logic [NUM_BR*HIST_W-1:0] hist_flat;
    logic [DEPTH-1:0]         ctr_flat;
    logic [HIST_W-1:0]        cur_hist;
    dir_e                     guess;
    logic                     mispredict;
    logic [HIST_W-1:0]        repair_val;

    // Pick the history of the branch being predicted.
    always_comb begin
        cur_hist = hist_flat[int'(pred_br)*HIST_W +: HIST_W];
    end

    // Detect a wrong guess and form the repaired history.
    always_comb begin
        mispredict = res_valid && (res_taken != res_pred_taken);
        repair_val = {res_ckpt[HIST_W-2:0], res_taken};
    end

    lhp_history_bank #(
        .NUM_BR (NUM_BR),
        .HIST_W (HIST_W)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .spec_we   (pred_valid),
        .spec_idx  (pred_br),
        .spec_bit  (guess),
        .fix_we    (mispredict),
        .fix_idx   (res_br),
        .fix_val   (repair_val),
        .hist_flat (hist_flat)
    );

    logic ctr_rd;

    lhp_counter_table #(
        .HIST_W (HIST_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cur_hist),
        .rd_bit   (ctr_rd),
        .wr_en    (res_valid),
        .wr_idx   (res_ckpt),
        .wr_bit   (res_taken),
        .ctr_flat (ctr_flat)
    );

    // Drive the predict outputs from the current history and its counter.
    always_comb begin
        guess      = dir_e'(ctr_rd);
        pred_taken = guess;
        pred_ckpt  = cur_hist;
    end

endmodule

// File: rtl/lhp_local_predictor_chk.sv
// Module: property checker for the local-history predictor, bound to the top.
// Assumes: it sees the top's ports plus its flattened history and counter state.
module lhp_local_predictor_chk #(
    parameter int NUM_BR = 4,
    parameter int HIST_W = 3,
    localparam int BR_W  = $clog2(NUM_BR),
    localparam int DEPTH = 1 << HIST_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     pred_valid,
    input logic [BR_W-1:0]          pred_br,
    input logic                     pred_taken,
    input logic [HIST_W-1:0]        pred_ckpt,
    input logic                     res_valid,
    input logic [BR_W-1:0]          res_br,
    input logic [HIST_W-1:0]        res_ckpt,
    input logic                     res_taken,
    input logic                     res_pred_taken,
    input logic [NUM_BR*HIST_W-1:0] hist_flat,
    input logic [DEPTH-1:0]         ctr_flat
);

    function automatic logic [HIST_W-1:0] hist_of(input logic [NUM_BR*HIST_W-1:0] f,
                                                  input logic [BR_W-1:0] i);
        return f[int'(i)*HIST_W +: HIST_W];
    endfunction

    logic wrong;
    logic same_hit;
    // Classify this cycle's resolution for the properties below.
    always_comb begin
        wrong    = res_valid && (res_taken != res_pred_taken);
        same_hit = wrong && pred_valid && (res_br == pred_br);
    end

    // R1: a reset edge leaves all state cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (hist_flat == '0 && ctr_flat == '0));

    // R2: the direction equals the table entry at the returned checkpoint.
    a_r2_dir_from_table: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> (pred_taken == ctr_flat[pred_ckpt]));

    // R4: an uncontested prediction shifts the guess into bit 0.
    a_r4_spec_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !same_hit) |=>
        (hist_of(hist_flat, $past(pred_br)) == {$past(pred_ckpt[HIST_W-2:0]), $past(pred_taken)}));

    // R5: no prediction and no repair keeps all histories.
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_valid && !wrong) |=> $stable(hist_flat));

    // R6: a valid resolution writes the outcome at the checkpoint.
    a_r6_ctr_write: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (ctr_flat[$past(res_ckpt)] == $past(res_taken)));

    // R7 and R9: a wrong guess rebuilds the history, even against a prediction.
    a_r7_repair: assert property (@(posedge clk) disable iff (!rst_n)
        wrong |=> (hist_of(hist_flat, $past(res_br)) == {$past(res_ckpt[HIST_W-2:0]), $past(res_taken)}));

    // R10: with no valid resolution the counters do not move.
    a_r10_no_ctr_write: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(ctr_flat));

endmodule

bind lhp_local_predictor lhp_local_predictor_chk #(
    .NUM_BR (NUM_BR),
    .HIST_W (HIST_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pred_valid     (pred_valid),
    .pred_br        (pred_br),
    .pred_taken     (pred_taken),
    .pred_ckpt      (pred_ckpt),
    .res_valid      (res_valid),
    .res_br         (res_br),
    .res_ckpt       (res_ckpt),
    .res_taken      (res_taken),
    .res_pred_taken (res_pred_taken),
    .hist_flat      (hist_flat),
    .ctr_flat       (ctr_flat)
);

// File: tb/test_lhp_local_predictor.sv
// Bench: vector table walked by one loop, then a directed reset test.
module test_lhp_local_predictor;

    localparam int NUM_BR = 4;
    localparam int HIST_W = 3;
    localparam int NVEC   = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pred_valid = 1'b0;
    logic [1:0] pred_br = '0;
    logic       pred_taken;
    logic [2:0] pred_ckpt;
    logic       res_valid = 1'b0;
    logic [1:0] res_br = '0;
    logic [2:0] res_ckpt = '0;
    logic       res_taken = 1'b0;
    logic       res_pred_taken = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    lhp_local_predictor #(.NUM_BR(NUM_BR), .HIST_W(HIST_W)) i_lhp_local_predictor (
        .clk(clk), .rst_n(rst_n),
        .pred_valid(pred_valid), .pred_br(pred_br),
        .pred_taken(pred_taken), .pred_ckpt(pred_ckpt),
        .res_valid(res_valid), .res_br(res_br), .res_ckpt(res_ckpt),
        .res_taken(res_taken), .res_pred_taken(res_pred_taken)
    );

    // Fields: pv, pbr, rv, rbr, rckpt, rtaken, rpred, exp_dir, exp_ckpt
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b1,2'd0, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b0,3'd0},  // 0  R2 R3 after reset
        {1'b1,2'd1, 1'b1,2'd0,3'd0,1'b1,1'b0, 1'b0,3'd0},  // 1  mispredict br0
        {1'b1,2'd0, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b0,3'd1},  // 2  R7 repaired br0
        {1'b1,2'd1, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b1,3'd0},  // 3  R6 ctr0=1
        {1'b1,2'd1, 1'b1,2'd1,3'd0,1'b1,1'b1, 1'b0,3'd1},  // 4  correct resolve br1
        {1'b1,2'd0, 1'b1,2'd0,3'd1,1'b1,1'b0, 1'b0,3'd2},  // 5  collide: repair wins
        {1'b1,2'd0, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b0,3'd3},  // 6  R9 br0=011
        {1'b1,2'd2, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b1,3'd0},  // 7  R4 br2
        {1'b1,2'd2, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b1,3'd1},  // 8  R4 shift taken
        {1'b1,2'd2, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b0,3'd3},  // 9  R4
        {1'b1,2'd2, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b0,3'd6},  // 10 R4
        {1'b1,2'd3, 1'b1,2'd1,3'd1,1'b0,1'b0, 1'b1,3'd0},  // 11 resolve writes ctr1=0
        {1'b1,2'd3, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b0,3'd1},  // 12 R6 ctr1 now 0
        {1'b1,2'd2, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b0,3'd4},  // 13 R4 top bit
        {1'b1,2'd2, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b1,3'd0},  // 14 R4 top bit dropped
        {1'b0,2'd2, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b0,3'd0},  // 15 idle
        {1'b1,2'd2, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b0,3'd1},  // 16 R5 held over idle
        {1'b1,2'd3, 1'b0,2'd3,3'd0,1'b0,1'b1, 1'b0,3'd2},  // 17 invalid resolve
        {1'b1,2'd3, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b0,3'd4},  // 18 R10 no repair
        {1'b1,2'd1, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b0,3'd2},  // 19 R8 br1 kept
        {1'b1,2'd3, 1'b0,2'd0,3'd0,1'b0,1'b0, 1'b1,3'd0}   // 20 R10 ctr0 kept
    };

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R2/R3 (R1 reset state)";
            2:       return "R7";
            3:       return "R6";
            6:       return "R9";
            7, 8, 9, 10, 13, 14: return "R4";
            12:      return "R6";
            16:      return "R5";
            18, 20:  return "R10";
            19:      return "R8";
            default: return "R2/R3";
        endcase
    endfunction

    task automatic check(input string tag, input logic ad, input logic [2:0] ac,
                         input logic ed, input logic [2:0] ec);
        n_tests++;
        if (ad !== ed || ac !== ec) begin
            n_fail++;
            $display("FAIL %s: dir=%0b ckpt=%0d expected dir=%0b ckpt=%0d",
                     tag, ad, ac, ed, ec);
        end
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            logic [14:0] v;
            v = VEC[i];
            pred_valid     = v[14];
            pred_br        = v[13:12];
            res_valid      = v[11];
            res_br         = v[10:9];
            res_ckpt       = v[8:6];
            res_taken      = v[5];
            res_pred_taken = v[4];
            #2;
            if (v[14]) check(tag_of(i), pred_taken, pred_ckpt, v[3], v[2:0]);
            @(negedge clk);
        end
        // Directed: R1 mid-run reset clears ctr0 (was 1) and br2 history (was 010).
        pred_valid = 1'b0;
        res_valid  = 1'b0;
        rst_n      = 1'b0;
        @(negedge clk);
        rst_n      = 1'b1;
        pred_valid = 1'b1;
        pred_br    = 2'd2;
        #2;
        check("R1 reset clears history and counters", pred_taken, pred_ckpt, 1'b0, 3'd0);
        @(negedge clk);
        pred_br = 2'd0;
        #2;
        check("R1 reset clears br0 history", pred_taken, pred_ckpt, 1'b0, 3'd0);
        @(negedge clk);
        pred_valid = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule